// File: doc/BRIEF.md
# Programmable-Factor Parallel-to-Serial Transmitter

This block turns parallel words from the core into one serial bit stream that runs on a fast bit clock. An internal counter divides the bit clock by the serialization factor. The counter produces two things: a one-cycle load strobe that moves the next word into the shift register, and a divided core clock whose rising edge lines up with each load. Logic on the core side launches a new word on every core-clock edge, and each word is shifted out once, most significant bit first.

The factor comes from a static input or from a fixed parameter, and can be any value from 3 to 10. In place of data, the serial path can send a forwarded-clock pattern, so that a data lane can carry the clock for its neighbours. A bypass mode skips the shift register. It routes core data bit 0 to the output through a single-rate register or through a plain wire. In double-rate form it sends data bit 1 in the high phase of the bit clock and bit 0 in the low phase.

Top module: `txs_serializer`

## Requirements
- R1: Words are up to 10 bits wide. With factor F, only bits F-1 down to 0 of `par_in` are sent, and the bits above F-1 have no effect on the serial output.
- R2: With `FIXED_FACTOR` = 0 the factor is `factor_i`, and any value below 3 or above 10 is treated as 10. A nonzero `FIXED_FACTOR` sets the factor and `factor_i` is ignored.
- R3: `load_stb_o` is high for exactly one bit-clock cycle in every F cycles. The word on `par_in` is captured at the rising edge that ends a cycle in which the strobe is high.
- R4: In serial mode (`byp_en_i`=0, `fwd_clk_en_i`=0), in the cycle after a load `ser_out` shows word bit F-1. It then shows one lower bit per cycle, with bit 0 in the F-th cycle, and the next word follows with no gap.
- R5: `core_clk_o` rises at each load edge, has a period of F bit cycles, and is high for the first (F+1)/2 cycles of each period (integer division).
- R6: Reset is synchronous and active low. While it is held, `ser_out` (in serial mode) is 0 and `load_stb_o` is 1. The first rising edge after release performs a load.
- R7: With `fwd_clk_en_i`=1 (and no bypass), each frame of F bits is (F+1)/2 ones followed by zeros, and `par_in` is ignored.
- R8: Bypass, single rate (`byp_en_i`=1, `byp_mode_i`=0): `ser_out` equals `par_in[0]` as registered at the previous rising edge.
- R9: Bypass, double rate (`byp_mode_i`=1): `par_in[1]` and `par_in[0]` are registered at a rising edge. `ser_out` shows bit 1 while the bit clock is high and bit 0 while it is low.
- R10: Bypass, unregistered (`byp_mode_i`=2 or 3): `ser_out` follows `par_in[0]` with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| factor_i | input | 4 | Static serialization factor |
| byp_en_i | input | 1 | Select the bypass path |
| byp_mode_i | input | 2 | Bypass form: 0 single rate, 1 double rate, 2/3 unregistered |
| fwd_clk_en_i | input | 1 | Send the forwarded-clock pattern instead of data |
| par_in | input | 10 | Parallel word from the core |
| ser_out | output | 1 | Serial output bit |
| load_stb_o | output | 1 | High in the cycle whose closing edge loads a word |
| core_clk_o | output | 1 | Bit clock divided by the factor |

## Verification
The assertions assume that `factor_i`, `FIXED_FACTOR` and the mode inputs only change while reset is held, or between whole frames. They also assume that in double-rate bypass the output is only meaningful at mid-phase, so no clocked property looks at that form. The stimulus changes the factor only inside a reset. It changes modes at falling edges while the scoreboard queue is empty. It drives `par_in` at falling edges and holds each word until the strobe comes round again, so every captured word is the one that was queued.

// File: rtl/txs_pkg.sv
// Shared defaults and the bypass-mode encoding for the serializer.
package txs_pkg;
    localparam int unsigned TXS_MAX_W = 10;  // widest word / largest factor
    localparam int unsigned TXS_MIN_F = 3;   // smallest legal factor

    typedef enum logic [1:0] {
        BYP_SDR     = 2'd0,
        BYP_DDR     = 2'd1,
        BYP_RAW     = 2'd2,
        BYP_RAW_ALT = 2'd3
    } byp_mode_e;
endpackage

// File: rtl/txs_factor_sel.sv
// Picks the effective factor: a fixed parameter or the static pin.
// Out-of-range values become MAX_W. Assumes the pin changes only in reset.
module txs_factor_sel #(
    parameter int unsigned MAX_W  = 10,
    parameter int unsigned MIN_F  = 3,
    parameter int unsigned FIXED  = 0,
    localparam int unsigned FW    = $clog2(MAX_W + 1)
) (
    input  logic [FW-1:0] factor_i,
    output logic [FW-1:0] eff_o
);
    generate
        if (FIXED != 0) begin : g_fixed
            localparam int unsigned FIX_EFF =
                (FIXED < MIN_F || FIXED > MAX_W) ? MAX_W : FIXED;
            logic unused_pin;
            assign unused_pin = ^factor_i;
            assign eff_o = FW'(FIX_EFF);
        end else begin : g_pin
            // clamp the pin value into the legal range
            always_comb begin
                if (factor_i < FW'(MIN_F) || factor_i > FW'(MAX_W))
                    eff_o = FW'(MAX_W);
                else
                    eff_o = factor_i;
            end
        end
    endgenerate
endmodule

// File: rtl/txs_load_gen.sv
// Divides the bit clock by the factor. The strobe marks the load cycle
// (count 0). The core clock is high for the first (F+1)/2 cycles after a load.
// Assumes eff_i is static outside reset.
module txs_load_gen #(
    parameter int unsigned FW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [FW-1:0] eff_i,
    output logic          load_o,
    output logic          core_clk_o
);
    logic [FW-1:0] cnt_q;
    logic [FW:0]   half_w;

    // cycle counter, wraps after eff-1
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_q == eff_i - 1'b1)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // strobe and divided clock decoded from the count
    always_comb begin
        half_w     = ({1'b0, eff_i} + 1'b1) >> 1;
        load_o     = (cnt_q == '0);
        core_clk_o = (cnt_q != '0) && ({1'b0, cnt_q} <= half_w);
    end
endmodule

// File: rtl/txs_shifter.sv
// Shift register, MSB out. On load it takes the word left-justified to
// bit MAX_W-1, or the forwarded-clock pattern. Otherwise it shifts left.
module txs_shifter #(
    parameter int unsigned MAX_W = 10,
    localparam int unsigned FW   = $clog2(MAX_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             fwd_i,
    input  logic [FW-1:0]    eff_i,
    input  logic [MAX_W-1:0] word_i,
    output logic             msb_o
);
    logic [MAX_W-1:0] sh_q;
    logic [MAX_W-1:0] pat_w;
    logic [FW:0]      ones_w;

    // forwarded-clock pattern: (F+1)/2 leading ones
    always_comb begin
        ones_w = ({1'b0, eff_i} + 1'b1) >> 1;
        pat_w  = '0;
        for (int k = 0; k < int'(MAX_W); k++) begin
            if (k < int'(ones_w))
                pat_w[MAX_W-1-k] = 1'b1;
        end
    end

    // load or shift
    always_ff @(posedge clk) begin
        if (!rst_n)
            sh_q <= '0;
        else if (load_i)
            sh_q <= fwd_i ? pat_w : (word_i << (FW'(MAX_W) - eff_i));
        else
            sh_q <= sh_q << 1;
    end

    assign msb_o = sh_q[MAX_W-1];
endmodule

// File: rtl/txs_bypass.sv
// Bypass path: single-rate register, double-rate pair muxed by the clock
// level, or a plain wire. Assumes the mode is static while in use.
module txs_bypass
    import txs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  byp_mode_e mode_i,
    input  logic [1:0] bits_i,
    output logic      out_o
);
    logic sdr_q, hi_q, lo_q;

    // capture registers for both registered forms
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdr_q <= 1'b0;
            hi_q  <= 1'b0;
            lo_q  <= 1'b0;
        end else begin
            sdr_q <= bits_i[0];
            hi_q  <= bits_i[1];
            lo_q  <= bits_i[0];
        end
    end

    // select the output form
    always_comb begin
        unique case (mode_i)
            BYP_SDR: out_o = sdr_q;
            BYP_DDR: out_o = clk ? hi_q : lo_q;
            default: out_o = bits_i[0];
        endcase
    end
endmodule

// File: rtl/txs_serializer.sv
// Top: factor select, load generator, shift register and bypass path.
// Assumes factor and mode inputs are static outside reset or between frames.
module txs_serializer
    import txs_pkg::*;
#(
    parameter int unsigned MAX_W        = TXS_MAX_W,
    parameter int unsigned MIN_F        = TXS_MIN_F,
    parameter int unsigned FIXED_FACTOR = 0,
    localparam int unsigned FW          = $clog2(MAX_W + 1)
) (
    input  logic             clk_fast,
    input  logic             rst_n,
    input  logic [FW-1:0]    factor_i,
    input  logic             byp_en_i,
    input  logic [1:0]       byp_mode_i,
    input  logic             fwd_clk_en_i,
    input  logic [MAX_W-1:0] par_in,
    output logic             ser_out,
    output logic             load_stb_o,
    output logic             core_clk_o
);
    logic [FW-1:0] eff_w;
    logic          sh_bit_w;
    logic          byp_bit_w;

    txs_factor_sel #(.MAX_W(MAX_W), .MIN_F(MIN_F), .FIXED(FIXED_FACTOR)) u_fsel (
        .factor_i (factor_i),
        .eff_o    (eff_w)
    );

    txs_load_gen #(.FW(FW)) u_ldgen (
        .clk        (clk_fast),
        .rst_n      (rst_n),
        .eff_i      (eff_w),
        .load_o     (load_stb_o),
        .core_clk_o (core_clk_o)
    );

    txs_shifter #(.MAX_W(MAX_W)) u_shift (
        .clk    (clk_fast),
        .rst_n  (rst_n),
        .load_i (load_stb_o),
        .fwd_i  (fwd_clk_en_i),
        .eff_i  (eff_w),
        .word_i (par_in),
        .msb_o  (sh_bit_w)
    );

    txs_bypass u_byp (
        .clk    (clk_fast),
        .rst_n  (rst_n),
        .mode_i (byp_mode_e'(byp_mode_i)),
        .bits_i (par_in[1:0]),
        .out_o  (byp_bit_w)
    );

    // output select between serial and bypass
    assign ser_out = byp_en_i ? byp_bit_w : sh_bit_w;
endmodule

// File: rtl/txs_serializer_chk.sv
// Assertion checker for txs_serializer, attached by bind. Assumes factor
// and modes are static outside reset; double-rate bypass is not checked here.
module txs_serializer_chk #(
    parameter int unsigned MAX_W        = 10,
    parameter int unsigned MIN_F        = 3,
    parameter int unsigned FIXED_FACTOR = 0,
    localparam int unsigned FW          = $clog2(MAX_W + 1)
) (
    input logic             clk_fast,
    input logic             rst_n,
    input logic [FW-1:0]    factor_i,
    input logic             byp_en_i,
    input logic [1:0]       byp_mode_i,
    input logic             fwd_clk_en_i,
    input logic [MAX_W-1:0] par_in,
    input logic             ser_out,
    input logic             load_stb_o,
    input logic             core_clk_o
);
    localparam int unsigned GW = FW + 1;
    logic [FW-1:0] exp_f;
    logic [GW-1:0] gap_q;
    logic          seen_q;

    // expected factor, modelled from the rules
    always_comb begin
        if (FIXED_FACTOR != 0)
            exp_f = (FIXED_FACTOR < MIN_F || FIXED_FACTOR > MAX_W) ? FW'(MAX_W) : FW'(FIXED_FACTOR);
        else if (factor_i < FW'(MIN_F) || factor_i > FW'(MAX_W))
            exp_f = FW'(MAX_W);
        else
            exp_f = factor_i;
    end

    // cycles since last strobe
    always_ff @(posedge clk_fast) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (load_stb_o) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (gap_q != '1) begin
            gap_q  <= gap_q + 1'b1;
        end
    end

    AST_LOAD_GAP: assert property (@(posedge clk_fast) disable iff (!rst_n)
        load_stb_o && seen_q |-> gap_q == GW'(exp_f) - 1'b1); // R3
    AST_LOAD_ONE_CYCLE: assert property (@(posedge clk_fast) disable iff (!rst_n)
        rst_n && load_stb_o |=> !load_stb_o); // R3
    AST_CORE_CLK_RISE: assert property (@(posedge clk_fast) disable iff (!rst_n)
        $rose(core_clk_o) |-> $past(load_stb_o)); // R5
    AST_MSB_FIRST: assert property (@(posedge clk_fast) disable iff (!rst_n)
        rst_n && load_stb_o && !byp_en_i && !fwd_clk_en_i
        |=> (byp_en_i || fwd_clk_en_i || ser_out == $past(par_in[exp_f - 1'b1]))); // R4
    AST_FWD_LEADS_HIGH: assert property (@(posedge clk_fast) disable iff (!rst_n)
        rst_n && load_stb_o && !byp_en_i && fwd_clk_en_i
        |=> (byp_en_i || !fwd_clk_en_i || ser_out)); // R7
    AST_BYP_SDR: assert property (@(posedge clk_fast) disable iff (!rst_n)
        rst_n && byp_en_i && byp_mode_i == 2'd0
        |=> (!byp_en_i || byp_mode_i != 2'd0 || ser_out == $past(par_in[0]))); // R8
endmodule

bind txs_serializer txs_serializer_chk #(
    .MAX_W(MAX_W), .MIN_F(MIN_F), .FIXED_FACTOR(FIXED_FACTOR)
) u_chk (
    .clk_fast     (clk_fast),
    .rst_n        (rst_n),
    .factor_i     (factor_i),
    .byp_en_i     (byp_en_i),
    .byp_mode_i   (byp_mode_i),
    .fwd_clk_en_i (fwd_clk_en_i),
    .par_in       (par_in),
    .ser_out      (ser_out),
    .load_stb_o   (load_stb_o),
    .core_clk_o   (core_clk_o)
);

// File: tb/test_txs_serializer.sv
module test_txs_serializer;
    localparam int CLK_PERIOD = 10;
    localparam int W = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   factor = 4'd8;
    logic         byp_en = 1'b0;
    logic [1:0]   byp_mode = 2'd0;
    logic         fwd = 1'b0;
    logic [W-1:0] word = '0;
    logic ser_out, load_stb, core_clk;
    logic ser2, load2, core2;

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct { logic v; string tag; } exp_t;
    exp_t q[$];
    exp_t mon_e;

    always #(CLK_PERIOD/2) clk = ~clk;

    txs_serializer i_txs_serializer (
        .clk_fast(clk), .rst_n(rst_n), .factor_i(factor), .byp_en_i(byp_en),
        .byp_mode_i(byp_mode), .fwd_clk_en_i(fwd), .par_in(word),
        .ser_out(ser_out), .load_stb_o(load_stb), .core_clk_o(core_clk));

    txs_serializer #(.FIXED_FACTOR(5)) i_txs_serializer_fixed (
        .clk_fast(clk), .rst_n(rst_n), .factor_i(factor), .byp_en_i(1'b0),
        .byp_mode_i(2'd0), .fwd_clk_en_i(1'b0), .par_in(word),
        .ser_out(ser2), .load_stb_o(load2), .core_clk_o(core2));

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int model_f(input int f);
        return (f < 3 || f > 10) ? 10 : f;
    endfunction

    // monitor: compare one queued bit per cycle, mid-high phase
    always begin
        @(posedge clk);
        #3;
        if (q.size() > 0) begin
            mon_e = q.pop_front();
            chk(ser_out === mon_e.v, mon_e.tag, int'(ser_out), int'(mon_e.v));
        end
    end

    // driver: present a word for the next load and queue its bits
    task automatic send(input logic [W-1:0] w, input string tag);
        int f = model_f(int'(factor));
        @(negedge clk);
        while (!load_stb) @(negedge clk);
        word = w;
        for (int k = f - 1; k >= 0; k--) begin
            exp_t e;
            e.tag = tag;
            e.v = fwd ? ((f - 1 - k) < (f + 1) / 2) : w[k];
            q.push_back(e);
        end
    endtask

    task automatic drain();
        while (q.size() > 0) @(posedge clk);
        @(negedge clk);
    endtask

    // reset with a new factor; checks R6 during and right after reset
    task automatic do_reset(input logic [3:0] f);
        int ef = model_f(int'(f));
        @(negedge clk);
        rst_n = 1'b0; factor = f; byp_en = 1'b0; fwd = 1'b0; word = '1;
        repeat (2) @(negedge clk);
        @(posedge clk); #3;
        chk(ser_out == 1'b0, "R6 serial low in reset", int'(ser_out), 0);
        chk(load_stb == 1'b1, "R6 strobe high in reset", int'(load_stb), 1);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #3;
        chk(load_stb == 1'b0, "R6 load at first edge", int'(load_stb), 0);
        chk(ser_out == word[ef-1], "R6 first word out", int'(ser_out), int'(word[ef-1]));
    endtask

    // frame timing of strobe and core clock (R3, R5)
    task automatic frame_timing(input string tag);
        int f = model_f(int'(factor));
        @(posedge clk); #3;
        while (!load_stb) begin @(posedge clk); #3; end
        for (int k = 0; k < f; k++) begin
            @(posedge clk); #3;
            chk(core_clk == (k < (f + 1) / 2), {tag, " R5 core clock"}, int'(core_clk), int'(k < (f + 1) / 2));
            chk(load_stb == (k == f - 1), {tag, " R3 strobe"}, int'(load_stb), int'(k == f - 1));
        end
    endtask

    task automatic gap_fixed(input int exp);
        int g = 0;
        @(posedge clk); #3;
        while (!load2) begin @(posedge clk); #3; end
        @(posedge clk); #3; g = 1;
        while (!load2 && g < 40) begin @(posedge clk); #3; g++; end
        chk(g == exp, "R2 fixed factor period", g, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R4 / R1: factor 8, upper bits must not matter
        do_reset(4'd8);
        send(10'h3A5, "R1 upper bits ignored");
        send(10'h03C, "R4 msb first");
        send(10'h081, "R4 msb first");
        drain();
        frame_timing("F8");
        gap_fixed(5);                        // R2: pin 8, fixed 5

        do_reset(4'd3);
        send(10'h005, "R4 factor 3");
        send(10'h3FA, "R1 factor 3 upper ignored");
        drain();
        frame_timing("F3");

        do_reset(4'd10);
        send(10'h2B1, "R4 factor 10");
        send(10'h14E, "R4 factor 10");
        drain();
        frame_timing("F10");

        // R2 clamp of out-of-range pin values
        do_reset(4'd12);
        send(10'h355, "R2 clamp 12");
        drain();
        frame_timing("R2 clamp 12");
        gap_fixed(5);
        do_reset(4'd0);
        frame_timing("R2 clamp 0");
        do_reset(4'd2);
        send(10'h0F3, "R2 clamp 2");
        drain();
        frame_timing("R2 clamp 2");

        // R7 forwarded-clock pattern, data ignored
        do_reset(4'd7);
        drain();
        fwd = 1'b1;
        send(10'h000, "R7 forwarded clock");
        send(10'h3FF, "R7 forwarded clock");
        send(10'h2AA, "R7 forwarded clock");
        drain();
        do_reset(4'd4);
        drain();
        fwd = 1'b1;
        send(10'h3FF, "R7 forwarded clock F4");
        drain();

        // bypass forms
        do_reset(4'd6);
        drain();
        byp_en = 1'b1; byp_mode = 2'd0;
        for (int i = 0; i < 6; i++) begin
            logic b = logic'((i * 5 + 1) % 3 == 0);
            @(negedge clk); word = {9'h155, b};
            @(posedge clk); #3;
            chk(ser_out == b, "R8 single-rate bypass", int'(ser_out), int'(b));
        end
        byp_mode = 2'd1;
        for (int i = 0; i < 4; i++) begin
            logic [1:0] bb = 2'(i + 1);
            @(negedge clk); word = {8'h00, bb};
            @(posedge clk); #2;
            chk(ser_out == bb[1], "R9 double-rate high phase", int'(ser_out), int'(bb[1]));
            @(negedge clk); #2;
            chk(ser_out == bb[0], "R9 double-rate low phase", int'(ser_out), int'(bb[0]));
        end
        for (int m = 2; m < 4; m++) begin
            byp_mode = 2'(m);
            for (int i = 0; i < 3; i++) begin
                @(negedge clk); #1;
                word = {9'h000, logic'(i[0])};
                #1;
                chk(ser_out == logic'(i[0]), "R10 unregistered bypass", int'(ser_out), int'(i[0]));
            end
        end
        byp_en = 1'b0; byp_mode = 2'd0;

        repeat (3) @(posedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule